// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Unit

This execution unit performs 32x32 integer multiplication and multiply-accumulate for a core with 64-bit general registers. It holds two independent accumulator pairs, each made of a 32-bit high word and a 32-bit low word. A single valid strobe presents an instruction word and two source operand values. One cycle later the unit reports completion, updates the selected pair, and offers a writeback value and write enable for the destination register named in the instruction.

Six operations are decoded. Two plain multiplies, one signed and one unsigned, target pair 0. Two plain multiplies, one signed and one unsigned, target pair 1. A signed multiply-accumulate targets pair 0 and another targets pair 1. Every multiply and accumulate also copies the new low word into the destination register. Any other encoding raises a reserved-instruction flag and changes nothing. All 32-bit results are sign-extended to 64 bits on the way out.

Top module: `dmac_top`

## Requirements
- R1: Opcode 0x00 (bits 31:26) with function 0x18 (bits 5:0) and bits 10:6 zero forms the signed product of the low 32 bits of both operands. The upper operand bits are ignored. The product is written to pair 0 (high word to HI, low word to LO), and the low word is also written to rd (bits 15:11).
- R2: Opcode 0x00 with function 0x19 does the same as R1, but treats both operands as unsigned.
- R3: Opcode 0x1C with function 0x18 (signed) or 0x19 (unsigned) writes the product to pair 1 and its low word to rd.
- R4: Opcode 0x1C with function 0x00 adds the signed product to the 64-bit {HI,LO} of pair 0, wrapping modulo 2^64. The new low word goes to LO and to rd, and the new high word goes to HI.
- R5: Opcode 0x1C with function 0x20 performs the R4 accumulation on pair 1.
- R6: An operation that selects one pair leaves the other pair's HI and LO unchanged.
- R7: When rd is 0, rd_we_o stays low, but the selected pair is still updated.
- R8: rd_data_o and all four accumulator outputs carry the 32-bit value sign-extended to 64 bits.
- R9: A valid instruction word that matches none of R1 to R5 is rejected. This includes any word whose bits 10:6 are nonzero. A rejected word raises ri_exc_o together with done_o, writes no register and leaves both pairs unchanged.
- R10: done_o, rd_we_o and the results appear exactly one cycle after valid_i. With valid_i low, no done, no write and no pair change occur.
- R11: Synchronous reset clears both pairs and deasserts done_o, rd_we_o and ri_exc_o.
- R12: Accumulations issued on consecutive cycles to the same pair each build on the previous result, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word |
| rs_val_i | input | 64 | First source operand |
| rt_val_i | input | 64 | Second source operand |
| done_o | output | 1 | Completion pulse, one cycle after valid_i |
| ri_exc_o | output | 1 | Reserved-instruction flag |
| rd_we_o | output | 1 | Destination register write enable |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | 64 | Sign-extended writeback value |
| hi0_o | output | 64 | Pair 0 high word, sign-extended |
| lo0_o | output | 64 | Pair 0 low word, sign-extended |
| hi1_o | output | 64 | Pair 1 high word, sign-extended |
| lo1_o | output | 64 | Pair 1 low word, sign-extended |

## Verification
The hardest case to reach from the ports is an accumulation that reads a pair written on the immediately preceding cycle, while the other pair was written just before that. Only with that history does a stale read or a wrong pair select show up. The stimulus table drives its rows on consecutive cycles with valid_i held high. Pair 0 and pair 1 operations are interleaved, followed by two back-to-back accumulations on pair 0 and a product-then-accumulate sequence that wraps {HI,LO} through zero. A reference model in the bench tracks both pairs and checks all four accumulator outputs after every row.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int XLEN   = 64;
    localparam int HALF   = 32;
    localparam int NPAIR  = 2;
    localparam int PAIR_W = (NPAIR > 1) ? $clog2(NPAIR) : 1;
    localparam int REG_W  = 5;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_MMI     = 6'h1C;
    localparam logic [5:0] FN_MUL_S    = 6'h18;
    localparam logic [5:0] FN_MUL_U    = 6'h19;
    localparam logic [5:0] FN_MAC0     = 6'h00;
    localparam logic [5:0] FN_MAC1     = 6'h20;

    typedef struct packed {
        logic              legal;
        logic              is_signed;
        logic              accumulate;
        logic [PAIR_W-1:0] pair;
        logic [REG_W-1:0]  rd;
    } dec_t;

    typedef struct packed {
        logic [NPAIR-1:0][HALF-1:0] hi;
        logic [NPAIR-1:0][HALF-1:0] lo;
        logic                       done;
        logic                       ri;
        logic                       we;
        logic [REG_W-1:0]           rd_idx;
        logic [HALF-1:0]            rd_lo;
    } state_t;
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
    import dmac_pkg::*;
(
    input  logic [31:0] insn_i,
    output dec_t        dec_o
);
    logic [5:0] opc;
    logic [5:0] fn;
    logic [4:0] sa;
    logic       unused_fields;

    assign opc = insn_i[31:26];
    assign fn  = insn_i[5:0];
    assign sa  = insn_i[10:6];
    assign unused_fields = ^insn_i[25:16];

    always_comb begin
        dec_o            = '0;
        dec_o.rd         = insn_i[15:11];
        if (sa == 5'd0) begin
            if (opc == OPC_SPECIAL) begin
                if (fn == FN_MUL_S || fn == FN_MUL_U) begin
                    dec_o.legal     = 1'b1;
                    dec_o.is_signed = (fn == FN_MUL_S);
                    dec_o.pair      = PAIR_W'(0);
                end
            end else if (opc == OPC_MMI) begin
                unique case (fn)
                    FN_MUL_S, FN_MUL_U: begin
                        dec_o.legal     = 1'b1;
                        dec_o.is_signed = (fn == FN_MUL_S);
                        dec_o.pair      = PAIR_W'(1);
                    end
                    FN_MAC0: begin
                        dec_o.legal      = 1'b1;
                        dec_o.is_signed  = 1'b1;
                        dec_o.accumulate = 1'b1;
                        dec_o.pair       = PAIR_W'(0);
                    end
                    FN_MAC1: begin
                        dec_o.legal      = 1'b1;
                        dec_o.is_signed  = 1'b1;
                        dec_o.accumulate = 1'b1;
                        dec_o.pair       = PAIR_W'(1);
                    end
                    default: dec_o.legal = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/dmac_mult.sv
module dmac_mult #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           is_signed_i,
    output logic [2*W-1:0] prod_o
);
    logic signed [2*W-1:0] a_ext;
    logic signed [2*W-1:0] b_ext;

    assign a_ext  = {{W{is_signed_i & a_i[W-1]}}, a_i};
    assign b_ext  = {{W{is_signed_i & b_i[W-1]}}, b_i};
    assign prod_o = a_ext * b_ext;
endmodule

// File: rtl/dmac_sext.sv
module dmac_sext #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] val_o
);
    assign val_o = {{(OUT_W-IN_W){val_i[IN_W-1]}}, val_i};
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  logic [31:0] insn_i,
    input  logic [63:0] rs_val_i,
    input  logic [63:0] rt_val_i,
    output logic        done_o,
    output logic        ri_exc_o,
    output logic        rd_we_o,
    output logic [4:0]  rd_idx_o,
    output logic [63:0] rd_data_o,
    output logic [63:0] hi0_o,
    output logic [63:0] lo0_o,
    output logic [63:0] hi1_o,
    output logic [63:0] lo1_o
);
    localparam int ACC_W = 2 * HALF;

    dec_t               dec;
    logic [ACC_W-1:0]   prod;
    logic [ACC_W-1:0]   cur_acc;
    logic [ACC_W-1:0]   sum;
    state_t             st_d, st_q;
    logic [NPAIR-1:0][XLEN-1:0] hi_x, lo_x;
    logic               unused_upper;

    assign unused_upper = ^{rs_val_i[XLEN-1:HALF], rt_val_i[XLEN-1:HALF]};

    dmac_decode u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    dmac_mult #(.W(HALF)) u_mul (
        .a_i         (rs_val_i[HALF-1:0]),
        .b_i         (rt_val_i[HALF-1:0]),
        .is_signed_i (dec.is_signed),
        .prod_o      (prod)
    );

    always_comb begin
        cur_acc = {st_q.hi[dec.pair], st_q.lo[dec.pair]};
        sum     = (dec.accumulate ? cur_acc : '0) + prod;

        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.ri   = 1'b0;
        st_d.we   = 1'b0;
        if (valid_i) begin
            st_d.done = 1'b1;
            if (!dec.legal) begin
                st_d.ri = 1'b1;
            end else begin
                st_d.hi[dec.pair] = sum[ACC_W-1:HALF];
                st_d.lo[dec.pair] = sum[HALF-1:0];
                st_d.we           = (dec.rd != '0);
                st_d.rd_idx       = dec.rd;
                st_d.rd_lo        = sum[HALF-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair_out
        dmac_sext #(.IN_W(HALF), .OUT_W(XLEN)) u_sx_hi (
            .val_i (st_q.hi[p]),
            .val_o (hi_x[p])
        );
        dmac_sext #(.IN_W(HALF), .OUT_W(XLEN)) u_sx_lo (
            .val_i (st_q.lo[p]),
            .val_o (lo_x[p])
        );
    end

    dmac_sext #(.IN_W(HALF), .OUT_W(XLEN)) u_sx_rd (
        .val_i (st_q.rd_lo),
        .val_o (rd_data_o)
    );

    assign done_o   = st_q.done;
    assign ri_exc_o = st_q.ri;
    assign rd_we_o  = st_q.we;
    assign rd_idx_o = st_q.rd_idx;
    assign hi0_o    = hi_x[0];
    assign lo0_o    = lo_x[0];
    assign hi1_o    = hi_x[1];
    assign lo1_o    = lo_x[1];
endmodule

// File: rtl/dmac_checker.sv
module dmac_checker (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic        done_o,
    input logic        ri_exc_o,
    input logic        rd_we_o,
    input logic [4:0]  rd_idx_o,
    input logic [63:0] rd_data_o,
    input logic [63:0] hi0_o,
    input logic [63:0] lo0_o,
    input logic [63:0] hi1_o,
    input logic [63:0] lo1_o
);
    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> done_o); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!done_o && !rd_we_o && $stable(hi0_o) && $stable(lo0_o)
                      && $stable(hi1_o) && $stable(lo1_o))); // R10

    AST_REJECT_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        ri_exc_o |-> (!rd_we_o && $stable(hi0_o) && $stable(lo0_o)
                      && $stable(hi1_o) && $stable(lo1_o))); // R9

    AST_NO_WRITE_R0: assert property (@(posedge clk) disable iff (rst)
        rd_we_o |-> (rd_idx_o != 5'd0)); // R7

    AST_RD_EQUALS_LO: assert property (@(posedge clk) disable iff (rst)
        rd_we_o |-> (rd_data_o == lo0_o || rd_data_o == lo1_o)); // R4

    AST_OTHER_PAIR_KEPT: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (($stable(hi0_o) && $stable(lo0_o)) ||
                    ($stable(hi1_o) && $stable(lo1_o)))); // R6

    AST_DONE_WITH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (ri_exc_o || rd_we_o) |-> done_o); // R10
endmodule

bind dmac_top dmac_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .done_o    (done_o),
    .ri_exc_o  (ri_exc_o),
    .rd_we_o   (rd_we_o),
    .rd_idx_o  (rd_idx_o),
    .rd_data_o (rd_data_o),
    .hi0_o     (hi0_o),
    .lo0_o     (lo0_o),
    .hi1_o     (hi1_o),
    .lo1_o     (lo1_o)
);

// File: tb/dmac_top_tb.sv
`timescale 1ns/1ps
module dmac_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [63:0] rs_val_i = '0;
    logic [63:0] rt_val_i = '0;
    logic        done_o, ri_exc_o, rd_we_o;
    logic [4:0]  rd_idx_o;
    logic [63:0] rd_data_o, hi0_o, lo0_o, hi1_o, lo1_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    dmac_top u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i),
        .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .done_o(done_o),
        .ri_exc_o(ri_exc_o), .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o),
        .rd_data_o(rd_data_o), .hi0_o(hi0_o), .lo0_o(lo0_o),
        .hi1_o(hi1_o), .lo1_o(lo1_o)
    );

    typedef struct packed {
        logic [31:0] insn;
        logic [63:0] rs;
        logic [63:0] rt;
        logic        rej;
        logic        pair;
        logic        sgn;
        logic        acc;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'h00001818, 64'hFFFFFFFF_FFFFFFFE, 64'h00000000_00000003, 1'b0, 1'b0, 1'b1, 1'b0},
        '{32'h00002019, 64'h12345678_FFFFFFFF, 64'hABCDEF01_FFFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'h70002818, 64'h00000000_00000007, 64'hFFFFFFFF_FFFFFFFB, 1'b0, 1'b1, 1'b1, 1'b0},
        '{32'h70003019, 64'h00000000_80000000, 64'h00000000_00000002, 1'b0, 1'b1, 1'b0, 1'b0},
        '{32'h70003800, 64'h00000000_7FFFFFFF, 64'h00000000_7FFFFFFF, 1'b0, 1'b0, 1'b1, 1'b1},
        '{32'h70003800, 64'h00000000_7FFFFFFF, 64'h00000000_7FFFFFFF, 1'b0, 1'b0, 1'b1, 1'b1},
        '{32'h70004020, 64'hFFFFFFFF_FFFFFFFF, 64'h00000000_00000001, 1'b0, 1'b1, 1'b1, 1'b1},
        '{32'h70000000, 64'h00000000_00000003, 64'h00000000_00000004, 1'b0, 1'b0, 1'b1, 1'b1},
        '{32'h70000020, 64'h00000000_00000005, 64'h00000000_00000006, 1'b0, 1'b1, 1'b1, 1'b1},
        '{32'h70003801, 64'h00000000_00000009, 64'h00000000_00000009, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h70003840, 64'h00000000_00000009, 64'h00000000_00000009, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h00001810, 64'h00000000_00000009, 64'h00000000_00000009, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h0000181A, 64'h00000000_00000009, 64'h00000000_00000009, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h00001818, 64'hFFFFFFFF_FFFFFFFF, 64'h00000000_00000001, 1'b0, 1'b0, 1'b1, 1'b0},
        '{32'h70003800, 64'h00000000_00000001, 64'h00000000_00000001, 1'b0, 1'b0, 1'b1, 1'b1},
        '{32'h70000018, 64'h00000000_00000002, 64'h00000000_00000003, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    logic [31:0] m_hi [2];
    logic [31:0] m_lo [2];

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_pairs(input string req0, input string req1);
        chk(req0, "hi0", hi0_o, sx(m_hi[0]));
        chk(req0, "lo0", lo0_o, sx(m_lo[0]));
        chk(req1, "hi1", hi1_o, sx(m_hi[1]));
        chk(req1, "lo1", lo1_o, sx(m_lo[1]));
    endtask

    task automatic drive(input int i);
        valid_i  = 1'b1;
        insn_i   = VECS[i].insn;
        rs_val_i = VECS[i].rs;
        rt_val_i = VECS[i].rt;
    endtask

    task automatic check_row(input int i);
        vec_t        v;
        logic [63:0] p, base, r;
        logic        exp_we;
        string       tag, tsel, toth;
        v = VECS[i];
        if (v.rej)                 tag = "R9";
        else if (i == 5)           tag = "R12";
        else if (v.acc && v.pair)  tag = "R5";
        else if (v.acc)            tag = "R4";
        else if (v.pair)           tag = "R3";
        else if (!v.sgn)           tag = "R2";
        else                       tag = "R1";
        chk("R10", "done", {63'd0, done_o}, 64'd1);
        chk(tag, "ri_exc", {63'd0, ri_exc_o}, {63'd0, v.rej});
        exp_we = 1'b0;
        if (!v.rej) begin
            if (v.sgn) p = 64'($signed(v.rs[31:0])) * 64'($signed(v.rt[31:0]));
            else       p = {32'd0, v.rs[31:0]} * {32'd0, v.rt[31:0]};
            base = v.acc ? {m_hi[v.pair], m_lo[v.pair]} : 64'd0;
            r    = base + p;
            m_hi[v.pair] = r[63:32];
            m_lo[v.pair] = r[31:0];
            exp_we = (v.insn[15:11] != 5'd0);
            if (exp_we) begin
                chk(tag, "rd_idx", {59'd0, rd_idx_o}, {59'd0, v.insn[15:11]});
                chk({tag, "/R8"}, "rd_data", rd_data_o, sx(r[31:0]));
            end
        end
        chk(exp_we ? tag : "R7", "rd_we", {63'd0, rd_we_o}, {63'd0, exp_we});
        tsel = v.rej ? "R9" : {tag, "/R8"};
        toth = v.rej ? "R9" : "R6";
        if (v.pair) chk_pairs(toth, tsel);
        else        chk_pairs(tsel, toth);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        m_hi[0] = '0; m_lo[0] = '0; m_hi[1] = '0; m_lo[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk("R11", "done", {63'd0, done_o}, 64'd0);
        chk("R11", "rd_we", {63'd0, rd_we_o}, 64'd0);
        chk("R11", "ri_exc", {63'd0, ri_exc_o}, 64'd0);
        chk_pairs("R11", "R11");

        // Table walk, one row per cycle with valid held high
        drive(0);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check_row(i);
            if (i + 1 < NV) drive(i + 1);
            else            valid_i = 1'b0;
        end

        // R10: idle cycle with a live-looking accumulate word on the inputs
        insn_i   = 32'h70003800;
        rs_val_i = 64'd11;
        rt_val_i = 64'd13;
        @(negedge clk);
        chk("R10", "idle done", {63'd0, done_o}, 64'd0);
        chk("R10", "idle rd_we", {63'd0, rd_we_o}, 64'd0);
        chk_pairs("R10", "R10");

        // R11: reset mid-run clears both pairs
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_hi[0] = '0; m_lo[0] = '0; m_hi[1] = '0; m_lo[1] = '0;
        @(negedge clk);
        chk_pairs("R11", "R11");
        chk("R11", "done after reset", {63'd0, done_o}, 64'd0);

        // R4: accumulate from a cleared pair equals the plain product
        valid_i  = 1'b1;
        insn_i   = 32'h70001000;
        rs_val_i = 64'hFFFFFFFF_80000000;
        rt_val_i = 64'h00000000_80000000;
        @(negedge clk);
        valid_i = 1'b0;
        chk("R4", "hi0 after reset", hi0_o, 64'h00000000_40000000);
        chk("R4", "lo0 after reset", lo0_o, 64'd0);
        chk("R4", "rd_we", {63'd0, rd_we_o}, 64'd1);
        chk("R1", "rd_idx", {59'd0, rd_idx_o}, 64'd2);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule